// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into a queue of received characters. A free-running enable pulse at sixteen times the bit rate drives an oversampling framer. The framer finds the falling start edge and votes three samples around the middle of each bit. It assembles a 7- or 8-bit character, least significant bit first, with optional even or odd parity and one or two stop bits. Each completed character is written into a 16-entry queue as a 10-bit word. The word carries the data and two error flags, so every character keeps its own error status until it is read.

Two event outputs report on the queue. A one-cycle overrun pulse marks a character that completed while the queue was full; that character is dropped. An idle-timeout level rises when characters wait in the queue and the line has been quiet for four character times. A consumer pops entries one at a time. The oldest entry is always visible at the read port.

Top module: `serial_rx_tagged`

## Requirements
- R1: The line is sampled on `os_tick` pulses through a two-stage synchronizer. A low level seen while idle opens a start bit, which is abandoned with no queue entry if the majority of the three mid-bit samples (ticks 7, 8, 9 of the bit) is high.
- R2: Each data, parity and stop bit is decided by the majority of three mid-bit samples. Data arrives least significant bit first, and the stored entry holds it in bits 7:0. `cfg_data8`=1 selects 8 data bits and 0 selects 7; `cfg_par_en`=1 adds a parity bit after the data; `cfg_stop2`=1 selects two stop bits.
- R3: With 7 data bits selected, bit 7 of the stored entry is 0.
- R4: Entry bit 8 is 1 when the received parity bit disagrees with the data. `cfg_par_odd`=0 expects an even number of ones over data plus parity, and 1 expects an odd number. With parity disabled, bit 8 is 0 and `cfg_par_odd` has no effect.
- R5: Entry bit 9 is 1 when the first stop bit votes low; the character is still stored. A second stop bit is never checked.
- R6: The queue holds 16 entries in arrival order. `rd_entry` shows the oldest entry, `rd_pop` removes it, and `rd_count` gives the fill level. A pop while empty changes nothing.
- R7: A character completing while `rd_count` is 16 is discarded, the queue is left unchanged, and `overrun_evt` pulses high for exactly one cycle.
- R8: `idle_timeout` rises once the queue is non-empty and the framer has been idle for 4 character times, where a character time is 16 ticks times (1 + data bits + parity bit + stop bits). The count restarts on every stored character and every pop, and the flag clears on either event and whenever the queue is empty.
- R9: After reset `rd_count` is 0 and `idle_timeout` and `overrun_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| line_in | input | 1 | Asynchronous serial input, idle high |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_entry | output | 10 | Oldest entry: framing error, parity error, data[7:0] |
| rd_count | output | 5 | Number of stored entries, 0 to 16 |
| overrun_evt | output | 1 | One-cycle pulse when a character is dropped on a full queue |
| idle_timeout | output | 1 | Queue non-empty and line idle for 4 character times |

## Verification
A framer with a slipped tick phase or bit counter shows up at the port as shifted or wrong data in the very next entry. With 7-bit data it shows as a stop or parity level leaking into bit 7. A wrong parity or stop vote flips bit 8 or 9 of that same entry. A queue pointer or count error shows as entries that are out of order, duplicated or missing, or as a wrong `rd_count`, on the first pop after the fault. Timer faults appear within one character time of the four-character threshold, as `idle_timeout` rising early, late, or while the queue is empty.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int ENTRY_W  = 10;
  localparam int DATA_W   = 8;
  localparam int PERR_POS = 8;
  localparam int FERR_POS = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP1T,
    ST_STOP2,
    ST_HOLD
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= STAGES'({q, din});
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_tick,
  input  logic               line_s,
  input  logic               cfg_data8,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               cfg_stop2,
  output logic               frm_push,
  output logic [ENTRY_W-1:0] frm_entry,
  output logic               frm_idle
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_A   = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] PH_B   = PW'(OSR/2);
  localparam logic [PW-1:0] PH_MID = PW'(OSR/2 + 1);
  localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

  rx_state_e         st;
  logic [PW-1:0]     ph;
  logic              smp_a, smp_b;
  logic [DATA_W-1:0] shf;
  logic [2:0]        nbit;
  logic              par_bad;
  logic              vote;
  logic [DATA_W-1:0] dword;
  logic [2:0]        last_bit;

  assign vote     = maj3(smp_a, smp_b, line_s);
  assign dword    = cfg_data8 ? shf : {1'b0, shf[DATA_W-1:1]};
  assign last_bit = cfg_data8 ? 3'd7 : 3'd6;
  assign frm_idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= '0;
      smp_a     <= 1'b1;
      smp_b     <= 1'b1;
      shf       <= '0;
      nbit      <= '0;
      par_bad   <= 1'b0;
      frm_push  <= 1'b0;
      frm_entry <= '0;
    end else begin
      frm_push <= 1'b0;
      if (smp_tick) begin
        if (st != ST_IDLE) ph <= (ph == PH_END) ? '0 : ph + 1'b1;
        if (ph == PH_A) smp_a <= line_s;
        if (ph == PH_B) smp_b <= line_s;
        unique case (st)
          ST_IDLE: begin
            if (!line_s) begin
              st      <= ST_START;
              ph      <= '0;
              nbit    <= '0;
              par_bad <= 1'b0;
            end
          end
          ST_START: begin
            if (ph == PH_MID && vote) st <= ST_IDLE;
            else if (ph == PH_END)    st <= ST_DATA;
          end
          ST_DATA: begin
            if (ph == PH_MID) shf <= {vote, shf[DATA_W-1:1]};
            if (ph == PH_END) begin
              nbit <= nbit + 1'b1;
              if (nbit == last_bit) st <= cfg_par_en ? ST_PAR : ST_STOP1;
            end
          end
          ST_PAR: begin
            if (ph == PH_MID) par_bad <= (^dword) ^ vote ^ cfg_par_odd;
            if (ph == PH_END) st <= ST_STOP1;
          end
          ST_STOP1: begin
            if (ph == PH_MID) begin
              frm_push  <= 1'b1;
              frm_entry <= {~vote, par_bad, dword};
              if (!vote)          st <= ST_HOLD;
              else if (cfg_stop2) st <= ST_STOP1T;
              else                st <= ST_IDLE;
            end
          end
          ST_STOP1T: if (ph == PH_END) st <= ST_STOP2;
          ST_STOP2:  if (ph == PH_MID) st <= ST_IDLE;
          ST_HOLD:   if (line_s) st <= ST_IDLE;
          default:   st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_entry_fifo.sv
module rx_entry_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      unique case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int OSR        = 16,
  parameter int TOUT_CHARS = 4,
  localparam int MAXT      = 12 * OSR * TOUT_CHARS,
  localparam int TW        = $clog2(MAXT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_tick,
  input  logic frm_idle,
  input  logic q_nonempty,
  input  logic restart,
  input  logic cfg_data8,
  input  logic cfg_par_en,
  input  logic cfg_stop2,
  output logic timeout
);
  logic [3:0]    char_bits;
  logic [TW-1:0] limit;
  logic [TW-1:0] cnt;

  assign char_bits = 4'd1 + (cfg_data8 ? 4'd8 : 4'd7) + {3'b000, cfg_par_en}
                   + (cfg_stop2 ? 4'd2 : 4'd1);
  assign limit = TW'(char_bits) * TW'(OSR * TOUT_CHARS);

  always_ff @(posedge clk) begin
    if (rst || restart || !q_nonempty) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (smp_tick && frm_idle && !timeout) begin
      if (cnt == limit - 1'b1) timeout <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int TOUT_CHARS  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               os_tick,
  input  logic               line_in,
  input  logic               cfg_data8,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               cfg_stop2,
  input  logic               rd_pop,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [CNT_W-1:0]   rd_count,
  output logic               overrun_evt,
  output logic               idle_timeout
);
  logic               line_s;
  logic               frm_push;
  logic [ENTRY_W-1:0] frm_entry;
  logic               frm_idle;
  logic               q_full;
  logic               q_nonempty;
  logic               tmr_restart;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
  );

  rx_frame_fsm #(.OSR(OSR)) u_frm (
    .clk(clk), .rst(rst), .smp_tick(os_tick), .line_s(line_s),
    .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .frm_push(frm_push), .frm_entry(frm_entry), .frm_idle(frm_idle)
  );

  rx_entry_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_q (
    .clk(clk), .rst(rst), .wr_en(frm_push), .wr_data(frm_entry),
    .rd_en(rd_pop), .rd_data(rd_entry), .count(rd_count), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun_evt <= 1'b0;
    else     overrun_evt <= frm_push && q_full;
  end

  assign q_nonempty  = (rd_count != '0);
  assign tmr_restart = frm_push || (rd_pop && q_nonempty);

  rx_idle_timer #(.OSR(OSR), .TOUT_CHARS(TOUT_CHARS)) u_tmr (
    .clk(clk), .rst(rst), .smp_tick(os_tick), .frm_idle(frm_idle),
    .q_nonempty(q_nonempty), .restart(tmr_restart),
    .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
    .timeout(idle_timeout)
  );
endmodule

// File: rtl/serial_rx_tagged_chk.sv
module serial_rx_tagged_chk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_pop,
  input logic             cfg_data8,
  input logic [9:0]       rd_entry,
  input logic [CNT_W-1:0] rd_count,
  input logic             overrun_evt,
  input logic             idle_timeout
);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(rd_count) <= DEPTH);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_count) <= int'($past(rd_count)) + 1) &&
    (int'(rd_count) + 1 >= int'($past(rd_count))));

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_count == '0 && rd_pop) |=> int'(rd_count) <= 1);

  assert_ovr_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    overrun_evt |-> int'($past(rd_count)) == DEPTH);

  assert_ovr_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun_evt && !$past(rd_pop)) |-> int'(rd_count) == DEPTH);

  assert_ovr_single_R7: assert property (@(posedge clk) disable iff (rst)
    overrun_evt |=> !overrun_evt);

  assert_tout_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    idle_timeout |-> rd_count != '0);

  assert_tout_pop_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && rd_count != '0) |=> !idle_timeout);

  assert_bit7_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_count != '0 && !cfg_data8) |-> !rd_entry[7]);
endmodule

bind serial_rx_tagged serial_rx_tagged_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_pop(rd_pop), .cfg_data8(cfg_data8),
  .rd_entry(rd_entry), .rd_count(rd_count),
  .overrun_evt(overrun_evt), .idle_timeout(idle_timeout)
);

// File: tb/tb_serial_rx_tagged.sv
module tb_serial_rx_tagged;
  localparam int DEPTH = 16;
  localparam int OSR   = 16;
  localparam int TOC   = 4;

  logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0, line_in = 1'b1;
  logic cfg_data8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rd_pop = 1'b0;
  logic [9:0] rd_entry;
  logic [4:0] rd_count;
  logic overrun_evt, idle_timeout;
  logic [1:0] tdiv = 2'd0;
  int checks = 0, errors = 0, tick_count = 0, ovr_seen = 0;

  serial_rx_tagged dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .line_in(line_in),
    .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rd_pop(rd_pop), .rd_entry(rd_entry),
    .rd_count(rd_count), .overrun_evt(overrun_evt), .idle_timeout(idle_timeout)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  always @(posedge clk) begin
    if (os_tick) tick_count <= tick_count + 1;
    if (overrun_evt) ovr_seen <= ovr_seen + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_ticks(input int n);
    int t0;
    t0 = tick_count;
    wait (tick_count >= t0 + n);
    @(negedge clk);
  endtask

  task automatic hold_line(input logic v, input int n);
    line_in = v;
    wait_ticks(n);
  endtask

  task automatic send_char(input logic [7:0] d, input bit flip, input bit bad1, input bit bad2);
    int nb;
    logic p;
    nb = cfg_data8 ? 8 : 7;
    p  = cfg_par_odd ^ flip;
    hold_line(1'b0, OSR);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      hold_line(d[i], OSR);
    end
    if (cfg_par_en) hold_line(p, OSR);
    hold_line(!bad1, OSR);
    if (cfg_stop2) begin
      if (bad2) begin hold_line(1'b0, 12); hold_line(1'b1, 4); end
      else hold_line(1'b1, OSR);
    end
    hold_line(1'b1, 2);
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  function automatic int char_ticks();
    return OSR * (1 + (cfg_data8 ? 8 : 7) + (cfg_par_en ? 1 : 0) + (cfg_stop2 ? 2 : 1));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int exp;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset count", int'(rd_count), 0);
    check("R9 reset timeout", int'(idle_timeout), 0);
    check("R9 reset overrun", int'(overrun_evt), 0);

    // R2 R3 R4 R5: sweep every frame format with clean, parity-bad and stop-bad characters
    for (int c = 0; c < 16; c++) begin
      cfg_data8 = c[0]; cfg_par_en = c[1]; cfg_par_odd = c[2]; cfg_stop2 = c[3];
      for (int k = 0; k < 4; k++) begin
        d = 8'((c * 53 + k * 97 + 90) & 255);
        send_char(d, k == 2, k == 3, 1'b0);
      end
      check("R6 fill level after four characters", int'(rd_count), 4);
      for (int k = 0; k < 4; k++) begin
        d   = 8'((c * 53 + k * 97 + 90) & 255);
        exp = int'(cfg_data8 ? d : (d & 8'h7F));
        if (cfg_par_en && k == 2) exp += 256;
        if (k == 3) exp += 512;
        check("R2 R3 R4 R5 entry word", int'(rd_entry), exp);
        pop_one();
      end
    end

    // R1: short low pulse is rejected as a start bit
    cfg_data8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    hold_line(1'b0, 4);
    hold_line(1'b1, 40);
    check("R1 glitch gives no entry", int'(rd_count), 0);

    // R5: second stop bit low is not checked
    cfg_stop2 = 1'b1;
    send_char(8'hC3, 1'b0, 1'b0, 1'b1);
    hold_line(1'b1, 40);
    check("R5 second stop unchecked count", int'(rd_count), 1);
    check("R5 second stop unchecked entry", int'(rd_entry), 'hC3);
    pop_one();

    // R6: pop on empty queue
    cfg_stop2 = 1'b0;
    pop_one();
    pop_one();
    check("R6 pop while empty", int'(rd_count), 0);

    // R7: overrun on the seventeenth character
    for (int k = 0; k < DEPTH; k++) send_char(8'(k * 13 + 1), 1'b0, 1'b0, 1'b0);
    check("R7 full before overrun", int'(rd_count), DEPTH);
    check("R7 no overrun yet", ovr_seen, 0);
    send_char(8'hEE, 1'b0, 1'b0, 1'b0);
    check("R7 overrun pulse count", ovr_seen, 1);
    check("R7 count unchanged", int'(rd_count), DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      check("R7 R6 stored order", int'(rd_entry), (k * 13 + 1) & 255);
      pop_one();
    end
    check("R6 drained", int'(rd_count), 0);

    // R8: idle timeout
    wait_ticks(char_ticks() * TOC + 60);
    check("R8 no timeout while empty", int'(idle_timeout), 0);
    send_char(8'h5A, 1'b0, 1'b0, 1'b0);
    wait_ticks(char_ticks() * TOC - 18);
    check("R8 timeout not yet", int'(idle_timeout), 0);
    wait_ticks(20);
    check("R8 timeout raised", int'(idle_timeout), 1);
    pop_one();
    check("R8 timeout cleared by pop", int'(idle_timeout), 0);
    check("R8 queue empty after pop", int'(rd_count), 0);

    finish_run();
  end
endmodule